// File: doc/BRIEF.md
# Data-Side Micro Translation Buffer with Tree Pseudo-LRU Refill

This block is a four-slot, fully associative translation cache that sits between the load/store address path and a larger joint translation table. On every cycle the requester presents a virtual address and an address-space identifier. The block compares the pair against all four slots at once. On a match it returns the physical address in the same cycle. The page offset (the low 12 bits) is passed through unchanged, because every slot maps a fixed 4 KB page.

When no slot matches, the block asks the joint table for the missing mapping on a level-held request. It raises a stall toward the requester and ignores new lookups until the answer arrives. It then writes the returned 24-bit frame number into a victim slot. The victim is chosen by a three-bit tree pseudo-LRU: within the pair of slots used less recently, it takes the entry used less recently. The refill is invisible to software. A flush input invalidates every slot in one cycle and also cancels a refill that is still waiting.

Top module: `utlb_top`

## Requirements
- R1: After reset every slot is invalid. No lookup hits, and `lk_stall` and `fill_req` are low.
- R2: While idle, a lookup (`lk_valid`) whose virtual page (`lk_vaddr[39:12]`) and `lk_asid` both equal a valid slot's key hits in the same cycle. `lk_paddr` = {slot frame number, `lk_vaddr[11:0]`}.
- R3: A lookup that matches no slot while idle reports no hit. From the next cycle, `fill_req` and `lk_stall` are high and `fill_vpn`/`fill_asid` carry the missed key. All of these stay steady until the response.
- R4: While `lk_stall` is high, lookups are ignored: `lk_hit` stays low, the pending key does not change, and the replacement state is not touched.
- R5: A `fill_ack` pulse while waiting writes the pending key and `fill_pfn` into the victim slot. In the next cycle `lk_stall` and `fill_req` are low and the key hits.
- R6: Replacement uses bits b0 (pair select), b1 (pair of slots 0/1) and b2 (pair of slots 2/3). The victim is slot (b0 ? (b2 ? 3 : 2) : (b1 ? 1 : 0)). Touching slot e sets b0 = ~e[1] and sets the bit of e's pair to ~e[0]. Touches happen on every hit and every refill.
- R7: `flush` invalidates every slot and sets b0..b2 to zero in one cycle. From an empty state, four successive refills therefore fill slots 0, 2, 1, 3.
- R8: A flush while waiting cancels the refill. The next cycle has `fill_req` and `lk_stall` low, and a later response is not installed.
- R9: A flush takes priority over a lookup in the same cycle. A missing key starts no refill, and a hit does not touch the replacement state.
- R10: At most one valid slot ever matches a key.
- R11: A `fill_ack` pulse while idle changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all slots, cancel a pending refill |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 40 | Virtual address (page number in bits 39:12) |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_stall | output | 1 | Refill outstanding, lookups ignored |
| lk_paddr | output | 36 | Translated physical address |
| fill_req | output | 1 | Request to the joint table, held until answered |
| fill_vpn | output | 28 | Virtual page being requested |
| fill_asid | output | 8 | Address-space identifier being requested |
| fill_ack | input | 1 | Joint table response valid |
| fill_pfn | input | 24 | Frame number returned by the joint table |

## Verification
The hardest state to reach from the ports is an eviction that depends on an uneven history of hits. The pseudo-LRU bits cannot be seen directly. They show up only when a later miss removes one particular older key. The bench keeps a small reference of the slots and the three bits, built from R6. It fills all four slots and re-touches them in chosen orders. It then forces new misses and checks which old keys have dropped out by looking them up again. Flushes are placed inside an outstanding refill and in the same cycle as a lookup, so that the cancel and priority paths are covered.

// File: rtl/utlb_pkg.sv
`timescale 1ns/1ps
package utlb_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = 2;
    localparam int PAGE_OFS  = 12;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } utlb_state_e;
endpackage

// File: rtl/utlb_match.sv
`timescale 1ns/1ps
module utlb_match
    import utlb_pkg::*;
#(
    parameter int KEY_W = 36,
    parameter int PFN_W = 24
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_SLOTS-1:0]                vld,
    input  logic [NUM_SLOTS-1:0][KEY_W-1:0]     keys,
    input  logic [NUM_SLOTS-1:0][PFN_W-1:0]     pfns,
    input  logic [KEY_W-1:0]                    probe,
    output logic [NUM_SLOTS-1:0]                hit_vec,
    output logic                                hit_any,
    output logic [SLOT_W-1:0]                   hit_idx,
    output logic [PFN_W-1:0]                    hit_pfn
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (keys[g] == probe);
    end

    always_comb begin
        hit_idx = '0;
        hit_pfn = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit_vec[i]) begin
                hit_idx = hit_idx | SLOT_W'(i);
                hit_pfn = hit_pfn | pfns[i];
            end
        end
    end

    assign hit_any = |hit_vec;

    // R10
    dup_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/utlb_plru.sv
`timescale 1ns/1ps
module utlb_plru
    import utlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              touch_en,
    input  logic [SLOT_W-1:0] touch_idx,
    output logic [SLOT_W-1:0] victim
);
    logic [2:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (clear) begin
            bits_d = '0;
        end else if (touch_en) begin
            bits_d[0] = ~touch_idx[1];
            if (touch_idx[1]) bits_d[2] = ~touch_idx[0];
            else              bits_d[1] = ~touch_idx[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign victim = bits_q[0] ? {1'b1, bits_q[2]} : {1'b0, bits_q[1]};

    // R6
    victim_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && !clear) |=> (victim != $past(touch_idx)));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (victim == '0));
endmodule

// File: rtl/utlb_top.sv
`timescale 1ns/1ps
module utlb_top
    import utlb_pkg::*;
#(
    parameter int VPN_W  = 28,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     lk_valid,
    input  logic [VPN_W+PAGE_OFS-1:0] lk_vaddr,
    input  logic [ASID_W-1:0]        lk_asid,
    output logic                     lk_hit,
    output logic                     lk_stall,
    output logic [PFN_W+PAGE_OFS-1:0] lk_paddr,
    output logic                     fill_req,
    output logic [VPN_W-1:0]         fill_vpn,
    output logic [ASID_W-1:0]        fill_asid,
    input  logic                     fill_ack,
    input  logic [PFN_W-1:0]         fill_pfn
);
    localparam int VA_W  = VPN_W + PAGE_OFS;
    localparam int KEY_W = VPN_W + ASID_W;

    typedef struct packed {
        utlb_state_e                         st;
        logic [NUM_SLOTS-1:0]                vld;
        logic [NUM_SLOTS-1:0][KEY_W-1:0]     key;
        logic [NUM_SLOTS-1:0][PFN_W-1:0]     pfn;
        logic [KEY_W-1:0]                    pend;
    } core_s;

    core_s d, q;

    logic [KEY_W-1:0]     probe;
    logic [NUM_SLOTS-1:0] mh_vec;
    logic                 mh_any;
    logic [SLOT_W-1:0]    mh_idx;
    logic [PFN_W-1:0]     mh_pfn;
    logic                 touch_en;
    logic [SLOT_W-1:0]    touch_idx;
    logic [SLOT_W-1:0]    victim;
    logic                 lookup_go;

    assign probe = {lk_vaddr[VA_W-1:PAGE_OFS], lk_asid};

    utlb_match #(.KEY_W(KEY_W), .PFN_W(PFN_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (q.vld),
        .keys    (q.key),
        .pfns    (q.pfn),
        .probe   (probe),
        .hit_vec (mh_vec),
        .hit_any (mh_any),
        .hit_idx (mh_idx),
        .hit_pfn (mh_pfn)
    );

    utlb_plru u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    assign lookup_go = lk_valid && (q.st == ST_IDLE);

    always_comb begin
        d         = q;
        touch_en  = 1'b0;
        touch_idx = mh_idx;
        if (flush) begin
            d.vld = '0;
            d.st  = ST_IDLE;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (lookup_go) begin
                        if (mh_any) begin
                            touch_en = 1'b1;
                        end else begin
                            d.st   = ST_FILL;
                            d.pend = probe;
                        end
                    end
                end
                ST_FILL: begin
                    if (fill_ack) begin
                        d.vld[victim] = 1'b1;
                        d.key[victim] = q.pend;
                        d.pfn[victim] = fill_pfn;
                        touch_en      = 1'b1;
                        touch_idx     = victim;
                        d.st          = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lk_hit    = lookup_go && mh_any;
    assign lk_paddr  = {mh_pfn, lk_vaddr[PAGE_OFS-1:0]};
    assign lk_stall  = (q.st == ST_FILL);
    assign fill_req  = (q.st == ST_FILL);
    assign fill_vpn  = q.pend[KEY_W-1:ASID_W];
    assign fill_asid = q.pend[ASID_W-1:0];

    // R3
    miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_stall && !lk_hit && !flush) |=> (fill_req && lk_stall));

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack && !flush) |=> ($stable(fill_vpn) && $stable(fill_asid) && fill_req));

    // R4
    stall_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stall |-> !lk_hit);

    // R5
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_ack && !flush) |=> !lk_stall);

    // R8
    flush_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!fill_req && !lk_stall));

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);
endmodule

// File: tb/utlb_top_test.sv
`timescale 1ns/1ps
module utlb_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [39:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_stall, fill_req;
    logic [35:0] lk_paddr;
    logic [27:0] fill_vpn;
    logic [7:0]  fill_asid;
    logic        fill_ack = 1'b0;
    logic [23:0] fill_pfn = '0;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    // reference model built from R6/R7
    logic        m_vld [4];
    logic [35:0] m_key [4];
    logic [23:0] m_pfn [4];
    logic [2:0]  m_plru;

    utlb_top uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_hit(lk_hit),
        .lk_stall(lk_stall), .lk_paddr(lk_paddr), .fill_req(fill_req),
        .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_ack(fill_ack),
        .fill_pfn(fill_pfn)
    );

    always #4 clk = ~clk;

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
            finish_run();
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] jt_pfn(input logic [27:0] vpn, input logic [7:0] asid);
        return 24'(vpn * 7 + {20'd0, asid} * 13 + 5);
    endfunction

    function automatic int m_find(input logic [35:0] key);
        for (int i = 0; i < 4; i++) if (m_vld[i] && m_key[i] == key) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        return m_plru[0] ? (m_plru[2] ? 3 : 2) : (m_plru[1] ? 1 : 0);
    endfunction

    task automatic m_touch(input int e);
        m_plru[0] = (e < 2);
        if (e >= 2) m_plru[2] = (e == 2);
        else        m_plru[1] = (e == 0);
    endtask

    task automatic m_clear();
        for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;
        m_plru = 3'b000;
    endtask

    // lookup with reference prediction; services a miss with the given latency
    task automatic access(input logic [27:0] vpn, input logic [7:0] asid,
                          input logic [11:0] ofs, input int lat, input string req);
        logic [35:0] key;
        int i;
        int v;
        logic [23:0] p;
        key = {vpn, asid};
        i = m_find(key);
        p = jt_pfn(vpn, asid);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, ofs}; lk_asid = asid;
        #1;
        if (i >= 0) begin
            chk(lk_hit == 1'b1, {req, "/R2 hit"}, 64'(lk_hit), 64'd1);
            chk(lk_paddr == {m_pfn[i], ofs}, {req, "/R2 paddr"}, 64'(lk_paddr), 64'({m_pfn[i], ofs}));
            @(negedge clk);
            lk_valid = 1'b0;
            m_touch(i);
        end else begin
            chk(lk_hit == 1'b0, {req, "/R3 miss"}, 64'(lk_hit), 64'd0);
            @(negedge clk);
            lk_valid = 1'b0;
            #1;
            chk(fill_req && lk_stall, {req, "/R3 req"}, 64'({fill_req, lk_stall}), 64'd3);
            chk({fill_vpn, fill_asid} == key, {req, "/R3 key"}, 64'({fill_vpn, fill_asid}), 64'(key));
            for (int k = 0; k < lat; k++) @(negedge clk);
            fill_ack = 1'b1; fill_pfn = p;
            @(negedge clk);
            fill_ack = 1'b0;
            #1;
            chk(!lk_stall && !fill_req, {req, "/R5 done"}, 64'({fill_req, lk_stall}), 64'd0);
            v = m_victim();
            m_vld[v] = 1'b1; m_key[v] = key; m_pfn[v] = p;
            m_touch(v);
        end
    endtask

    task automatic t_reset();
        #1;
        chk(!lk_stall && !fill_req, "R1 idle", 64'({fill_req, lk_stall}), 64'd0);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = 40'h12345_6789; lk_asid = 8'h00;
        #1;
        chk(lk_hit == 1'b0, "R1 no hit", 64'(lk_hit), 64'd0);
        lk_valid = 1'b0;
    endtask

    task automatic t_fill_four();
        for (int j = 0; j < 4; j++) access(28'h100 + 28'(j), 8'h5, 12'h0, j, "R5 fill");
        for (int j = 0; j < 4; j++) access(28'h100 + 28'(j), 8'h5, 12'hABC, 0, "R2 hit");
    endtask

    task automatic t_flush_order();
        // after a flush, fills should land in slots 0,2,1,3
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        m_clear();
        lk_valid = 1'b1; lk_vaddr = {28'h100, 12'h0}; lk_asid = 8'h5;
        #1;
        chk(lk_hit == 1'b0, "R7 flushed", 64'(lk_hit), 64'd0);
        lk_valid = 1'b0;
        // next access is a real miss on an empty table
        for (int j = 0; j < 4; j++) access(28'h200 + 28'(j), 8'h1, 12'h0, 1, "R7 refill");
        // slot order 0,2,1,3 => plru bits now point at slot 0 (key 200)
        access(28'h2FF, 8'h1, 12'h0, 0, "R7 evict");
        access(28'h200, 8'h1, 12'h0, 0, "R7 evicted gone");
        chk(m_find({28'h201, 8'h1}) < 0, "R7 model order", 64'(m_find({28'h201, 8'h1})), 64'hFFFFFFFFFFFFFFFF);
    endtask

    task automatic t_asid();
        access(28'h2FF, 8'h2, 12'h0, 0, "R2 asid key");
        access(28'h2FF, 8'h1, 12'h0, 0, "R2 asid other");
    endtask

    task automatic t_plru_pattern();
        logic [27:0] base;
        base = 28'h300;
        for (int j = 0; j < 4; j++) access(base + 28'(j), 8'h9, 12'h0, 0, "R6 load");
        access(base + 28'd3, 8'h9, 12'h0, 0, "R6 touch");
        access(base + 28'd0, 8'h9, 12'h0, 0, "R6 touch");
        access(base + 28'd2, 8'h9, 12'h0, 0, "R6 touch");
        access(base + 28'd8, 8'h9, 12'h0, 0, "R6 new");
        for (int j = 0; j < 4; j++) access(base + 28'(j), 8'h9, 12'h0, 0, "R6 probe");
    endtask

    task automatic t_stall_ignore();
        logic [35:0] key;
        int pres;
        pres = -1;
        for (int i = 0; i < 4; i++) if (m_vld[i] && pres < 0) pres = i;
        key = {28'h400, 8'h3};
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {28'h400, 12'h0}; lk_asid = 8'h3;
        @(negedge clk);
        lk_vaddr = {m_key[pres][35:8], 12'h0}; lk_asid = m_key[pres][7:0];
        #1;
        chk(lk_stall && !lk_hit, "R4 stall hides hit", 64'({lk_stall, lk_hit}), 64'd2);
        @(negedge clk);
        lk_valid = 1'b0;
        #1;
        chk({fill_vpn, fill_asid} == key, "R4 pend key", 64'({fill_vpn, fill_asid}), 64'(key));
        fill_ack = 1'b1; fill_pfn = 24'hABCDE;
        @(negedge clk);
        fill_ack = 1'b0;
        begin
            int v;
            v = m_victim();
            m_vld[v] = 1'b1; m_key[v] = key; m_pfn[v] = 24'hABCDE; m_touch(v);
        end
        access(28'h400, 8'h3, 12'h123, 0, "R4 installed");
        for (int j = 0; j < 3; j++) access(28'h500 + 28'(j), 8'h3, 12'h0, 0, "R4 plru untouched");
    endtask

    task automatic t_flush_wait();
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {28'h600, 12'h0}; lk_asid = 8'h7;
        @(negedge clk);
        lk_valid = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        m_clear();
        #1;
        chk(!fill_req && !lk_stall, "R8 cancel", 64'({fill_req, lk_stall}), 64'd0);
        fill_ack = 1'b1; fill_pfn = 24'h55555;
        @(negedge clk);
        fill_ack = 1'b0;
        access(28'h600, 8'h7, 12'h0, 0, "R8 not installed");
    endtask

    task automatic t_flush_priority();
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {28'h700, 12'h0}; lk_asid = 8'h7;
        flush = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0; flush = 1'b0;
        m_clear();
        #1;
        chk(!fill_req && !lk_stall, "R9 no refill", 64'({fill_req, lk_stall}), 64'd0);
        for (int j = 0; j < 2; j++) access(28'h710 + 28'(j), 8'h7, 12'h0, 0, "R9 load");
        // hit on slot 0 coinciding with flush must not touch plru
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {28'h710, 12'h0}; lk_asid = 8'h7;
        flush = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0; flush = 1'b0;
        m_clear();
        for (int j = 0; j < 4; j++) access(28'h720 + 28'(j), 8'h7, 12'h0, 0, "R9 order");
        access(28'h72F, 8'h7, 12'h0, 0, "R9 evict");
        access(28'h720, 8'h7, 12'h0, 0, "R9 evicted");
    endtask

    task automatic t_stray_ack();
        @(negedge clk);
        fill_ack = 1'b1; fill_pfn = 24'hFFFFF;
        @(negedge clk);
        fill_ack = 1'b0;
        #1;
        chk(!fill_req && !lk_stall, "R11 idle kept", 64'({fill_req, lk_stall}), 64'd0);
        for (int i = 0; i < 4; i++)
            if (m_vld[i]) access(m_key[i][35:8], m_key[i][7:0], 12'hFED, 0, "R11 slots kept");
    endtask

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_four();
        t_flush_order();
        t_asid();
        t_plru_pattern();
        t_stall_ignore();
        t_flush_wait();
        t_flush_priority();
        t_stray_ack();
        // R10: every present key reports exactly one translation
        for (int i = 0; i < 4; i++)
            if (m_vld[i]) access(m_key[i][35:8], m_key[i][7:0], 12'h001, 0, "R10 unique");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule